// File: doc/BRIEF.md
# Transmit FIFO with Watermark Request

This block is the transmit side of a serial I/O peripheral. It holds a 16-entry data FIFO. A CPU or a DMA engine fills the FIFO through a push port, and a serial shifter empties it through a pop port. A 16-bit control/status word holds two fields. The first is a programmable 3-bit watermark code. The second is a read-only 5-bit count of the words that can still be written, which reads 16 when the FIFO is empty and 0 when it is full.

The block asserts a transfer request whenever the number of empty stages reaches the level that the watermark code selects. Three codes are prohibited, and a write that carries one of them is rejected. When DMA mode is selected, the code that requests on any single free stage is flagged as illegal. Pushing while the FIFO is full and popping while it is empty each set a sticky error flag. A synchronous clear empties the FIFO and leaves the watermark setting in place.

Top module: `tx_fifo_wm`

## Requirements
- R1: After reset the control word reads 0x1000. The watermark field (bits 15:13) is 000, the usable-area field (bits 12:8) is 16 and bits 7:0 are zero. `tx_req` is 1, `ovf_flag`, `udf_flag` and `wm_illegal` are 0, and `rd_data` is 0.
- R2: Words leave the FIFO in the order they were pushed. `rd_data` takes the popped word on the clock edge that accepts the pop and holds it until the next accepted pop.
- R3: Bits 12:8 of the control word always equal 16 minus the occupancy. Sixteen accepted pushes from empty make the field read 0.
- R4: `tx_req` is 1 exactly when the number of empty stages is at least the threshold of the stored code. The thresholds are: code 000 needs 16, 100 needs 12, 101 needs 8, 110 needs 4 and 111 needs 1.
- R5: A control write stores bits 15:13 as the new watermark when the code is legal. A write carrying 001, 010 or 011 leaves the stored watermark unchanged. Written bits 12:0 have no effect.
- R6: `wm_illegal` is 1 exactly when `dma_mode` is 1 and the stored code is 111. Code 111 is still stored and still drives the request.
- R7: A push while the FIFO is full is dropped and sets `ovf_flag`, which stays set until reset or clear. The stored words are unaffected.
- R8: A pop while the FIFO is empty leaves `rd_data` at its last value and sets `udf_flag`, which stays set until reset or clear.
- R9: A push and a pop in the same cycle, with the FIFO neither full nor empty, leave the usable-area count unchanged. When the FIFO is full, the pop is taken and the push is dropped as an overflow. When the FIFO is empty, the push is taken and the pop is an underflow.
- R10: `fifo_clr` takes priority over push and pop in the same cycle. It makes the usable area 16, clears both sticky flags and keeps the watermark code.
- R11: `tx_req` follows the registered occupancy and watermark with no added delay. It changes right after the edge that accepts a push, a pop or a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous FIFO clear, keeps the watermark |
| dma_mode | input | 1 | High when the writer is a DMA engine |
| wr_en | input | 1 | Push request |
| wr_data | input | DW (16) | Word to push |
| rd_en | input | 1 | Pop request from the shifter |
| rd_data | output | DW (16) | Last popped word |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Control word readback |
| tx_req | output | 1 | Transfer request |
| wm_illegal | output | 1 | Code 111 selected while in DMA mode |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |

## Verification
The functions that can fall in the same cycle are the push from the writer and the pop from the shifter. The bench drives `wr_en` and `rd_en` together in three states: partly filled, full and empty. In each state it judges the usable-area field, the sticky flags and the later pop order against a queue model. A second overlap pits `fifo_clr` against a push in the same cycle, and the bench checks that the clear wins while the watermark survives.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned WM_W   = 3;
  localparam int unsigned UA_W   = 5;
  localparam int unsigned WM_LSB = 13;
  localparam int unsigned UA_LSB = 8;

  typedef logic [WM_W-1:0] wm_code_t;

  localparam wm_code_t WM_ALL_FREE = 3'b000;
  localparam wm_code_t WM_3QTR     = 3'b100;
  localparam wm_code_t WM_HALF     = 3'b101;
  localparam wm_code_t WM_1QTR     = 3'b110;
  localparam wm_code_t WM_ANY      = 3'b111;

  // prohibited codes are 001, 010 and 011
  function automatic logic wm_is_legal(input wm_code_t code);
    return !(code == 3'b001 || code == 3'b010 || code == 3'b011);
  endfunction

  // empty stages required before a request; unreachable for illegal codes
  function automatic int unsigned wm_threshold(input wm_code_t code,
                                               input int unsigned depth);
    case (code)
      WM_ALL_FREE: return depth;
      WM_3QTR:     return (depth * 3) / 4;
      WM_HALF:     return depth / 2;
      WM_1QTR:     return depth / 4;
      WM_ANY:      return 1;
      default:     return depth + 1;
    endcase
  endfunction

  function automatic logic wm_request(input wm_code_t code,
                                      input int unsigned free_cnt,
                                      input int unsigned depth);
    return free_cnt >= wm_threshold(code, depth);
  endfunction
endpackage

// File: rtl/txf_storage.sv
module txf_storage #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // output word holds across underflow and clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (pop_ok) rdata_q <= mem[rptr];
  end
endmodule

// File: rtl/txf_occupancy.sv
module txf_occupancy #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_ev,
  output logic          udf_ev,
  output logic [CW-1:0] free_cnt,
  output logic          ovf_sticky,
  output logic          udf_sticky
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] count_q;
  logic          full, empty;

  assign full     = (count_q == CAP);
  assign empty    = (count_q == '0);
  assign push_ok  = push_req && !full  && !clr;
  assign pop_ok   = pop_req  && !empty && !clr;
  assign ovf_ev   = push_req && full   && !clr;
  assign udf_ev   = pop_req  && empty  && !clr;
  assign free_cnt = CAP - count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      ovf_sticky <= 1'b0;
      udf_sticky <= 1'b0;
    end else if (clr) begin
      count_q    <= '0;
      ovf_sticky <= 1'b0;
      udf_sticky <= 1'b0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (ovf_ev) ovf_sticky <= 1'b1;
      if (udf_ev) udf_sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/txf_ctrl_reg.sv
module txf_ctrl_reg
  import txf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  wm_code_t         wcode,
  input  logic [UA_W-1:0]  free_field,
  output wm_code_t         wm_q,
  output logic             reject_ev,
  output logic [REG_W-1:0] rdata
);
  assign reject_ev = we && !wm_is_legal(wcode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wm_q <= WM_ALL_FREE;
    else if (we && wm_is_legal(wcode)) wm_q <= wcode;
  end

  // low byte belongs to the receive side and reads zero here
  assign rdata = {wm_q, free_field, {UA_LSB{1'b0}}};
endmodule

// File: rtl/txf_req_gen.sv
module txf_req_gen
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  wm_code_t      wm,
  input  logic [CW-1:0] free_cnt,
  input  logic          dma_mode,
  output logic          req,
  output logic          illegal
);
  assign req     = wm_request(wm, 32'(free_cnt), DEPTH);
  assign illegal = dma_mode && (wm == WM_ANY);
endmodule

// File: rtl/tx_fifo_wm.sv
module tx_fifo_wm
  import txf_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          dma_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          reg_we,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          tx_req,
  output logic          wm_illegal,
  output logic          ovf_flag,
  output logic          udf_flag
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  // internal events, named for the bound checker
  logic          push_ok, pop_ok, ovf_ev, udf_ev, reject_ev;
  logic [CW-1:0] free_cnt;
  wm_code_t      wm_q;
  logic [UA_W-1:0] free_field;

  assign free_field = UA_W'(free_cnt);

  txf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push_req(wr_en), .pop_req(rd_en),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .ovf_ev(ovf_ev), .udf_ev(udf_ev),
    .free_cnt(free_cnt),
    .ovf_sticky(ovf_flag), .udf_sticky(udf_flag)
  );

  txf_storage #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wdata(wr_data), .rdata_q(rd_data)
  );

  txf_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .wcode(reg_wdata[WM_LSB +: WM_W]),
    .free_field(free_field),
    .wm_q(wm_q), .reject_ev(reject_ev), .rdata(reg_rdata)
  );

  txf_req_gen #(.DEPTH(DEPTH)) u_req (
    .wm(wm_q), .free_cnt(free_cnt), .dma_mode(dma_mode),
    .req(tx_req), .illegal(wm_illegal)
  );
endmodule

// File: rtl/tx_fifo_wm_chk.sv
module tx_fifo_wm_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          dma_mode,
  input logic          reg_we,
  input logic [15:0]   reg_rdata,
  input logic [DW-1:0] rd_data,
  input logic          tx_req,
  input logic          wm_illegal,
  input logic          ovf_flag,
  input logic          udf_flag,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          ovf_ev,
  input logic          udf_ev,
  input logic          reject_ev
);
  localparam logic [4:0] ALL_FREE = 5'(DEPTH);

  logic [2:0] wm_f;
  logic [4:0] ua_f;
  assign wm_f = reg_rdata[15:13];
  assign ua_f = reg_rdata[12:8];

  AST_UA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ua_f <= ALL_FREE);  // R3
  AST_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_f == ALL_FREE) |-> tx_req);  // R4
  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_f == 5'd0) |-> !tx_req);  // R4
  AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (wm_f == $past(wm_f)));  // R5
  AST_DMA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && wm_f == 3'b111) |-> wm_illegal);  // R6
  AST_NO_FLAG_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    wm_illegal |-> dma_mode);  // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !fifo_clr) |=> ovf_flag);  // R7
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag);  // R7
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !pop_ok) |=> (ua_f == 5'd0));  // R7
  AST_UDF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    udf_ev |=> ($stable(rd_data) && udf_flag));  // R8
  AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(ua_f));  // R9
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (ua_f == ALL_FREE && !ovf_flag && !udf_flag));  // R10
  AST_CLR_KEEP_WM: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !reg_we) |=> $stable(wm_f));  // R10
endmodule

bind tx_fifo_wm tx_fifo_wm_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .dma_mode(dma_mode),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .rd_data(rd_data),
  .tx_req(tx_req), .wm_illegal(wm_illegal),
  .ovf_flag(ovf_flag), .udf_flag(udf_flag),
  .push_ok(push_ok), .pop_ok(pop_ok),
  .ovf_ev(ovf_ev), .udf_ev(udf_ev), .reject_ev(reject_ev)
);

// File: tb/sim_tx_fifo_wm.sv
`timescale 1ns/1ps
module sim_tx_fifo_wm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_clr = 0, dma_mode = 0, wr_en = 0, rd_en = 0, reg_we = 0;
  logic [15:0] wr_data = '0, reg_wdata = '0;
  logic [15:0] rd_data, reg_rdata;
  logic        tx_req, wm_illegal, ovf_flag, udf_flag;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tx_fifo_wm u0 (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .dma_mode(dma_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_req(tx_req), .wm_illegal(wm_illegal),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  // empty stages needed per code; 99 marks a prohibited code
  int need [8] = '{16, 99, 99, 99, 12, 8, 4, 1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_push(input logic [15:0] v);
    wr_en = 1; wr_data = v; tick(); wr_en = 0;
  endtask

  task automatic do_pop();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic do_both(input logic [15:0] v);
    wr_en = 1; rd_en = 1; wr_data = v; tick(); wr_en = 0; rd_en = 0;
  endtask

  task automatic do_regwr(input logic [15:0] v);
    reg_we = 1; reg_wdata = v; tick(); reg_we = 0;
  endtask

  task automatic do_clr();
    fifo_clr = 1; tick(); fifo_clr = 0;
  endtask

  function automatic int ua();
    return int'(reg_rdata[12:8]);
  endfunction

  task automatic t_reset();
    check(reg_rdata == 16'h1000, "R1 reg", reg_rdata, 16'h1000);
    check(tx_req == 1'b1, "R1 req", tx_req, 1);
    check({ovf_flag, udf_flag, wm_illegal} == 3'b000, "R1 flags",
          {ovf_flag, udf_flag, wm_illegal}, 0);
    check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    do_clr();
    for (int i = 0; i < 16; i++) begin
      do_push(16'hA000 + 16'(i));
      check(ua() == 15 - i, "R3 usable after push", ua(), 15 - i);
    end
    for (int i = 0; i < 16; i++) begin
      do_pop();
      check(rd_data == 16'hA000 + 16'(i), "R2 pop order", rd_data, 16'hA000 + i);
    end
    check(ua() == 16, "R3 usable empty", ua(), 16);
  endtask

  task automatic t_thresholds();
    logic [2:0] codes [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    foreach (codes[k]) begin
      do_clr();
      do_regwr({codes[k], 13'h0});
      check(reg_rdata[15:13] == codes[k], "R5 legal code stored", reg_rdata[15:13], codes[k]);
      for (int n = 0; n <= 16; n++) begin
        check(tx_req == ((16 - n) >= need[codes[k]]), "R4 R11 request level",
              tx_req, ((16 - n) >= need[codes[k]]));
        if (n < 16) do_push(16'(n));
      end
      for (int n = 15; n >= 0; n--) begin
        do_pop();
        check(tx_req == ((16 - n) >= need[codes[k]]), "R11 request on pop",
              tx_req, ((16 - n) >= need[codes[k]]));
      end
    end
  endtask

  task automatic t_reject();
    do_clr();
    do_regwr(16'hA000);  // code 101
    for (int c = 1; c <= 3; c++) begin
      do_regwr({3'(c), 13'h1FFF});
      check(reg_rdata[15:13] == 3'b101, "R5 prohibited ignored", reg_rdata[15:13], 3'b101);
      check(ua() == 16, "R5 low bits no effect", ua(), 16);
    end
  endtask

  task automatic t_dma();
    do_clr();
    do_regwr(16'hE000);
    dma_mode = 0; #1;
    check(wm_illegal == 1'b0, "R6 cpu mode no flag", wm_illegal, 0);
    dma_mode = 1; #1;
    check(wm_illegal == 1'b1, "R6 dma flag", wm_illegal, 1);
    check(reg_rdata[15:13] == 3'b111 && tx_req, "R6 code kept and requests",
          {reg_rdata[15:13], tx_req}, 4'hF);
    do_regwr(16'hC000);
    check(wm_illegal == 1'b0, "R6 legal in dma", wm_illegal, 0);
    dma_mode = 0;
  endtask

  task automatic t_overflow();
    do_clr();
    for (int i = 0; i < 16; i++) do_push(16'hB000 + 16'(i));
    check(ovf_flag == 1'b0, "R7 no flag at exactly full", ovf_flag, 0);
    do_push(16'hDEAD);
    check(ovf_flag == 1'b1, "R7 overflow flag", ovf_flag, 1);
    check(ua() == 0, "R7 still full", ua(), 0);
    for (int i = 0; i < 16; i++) begin
      do_pop();
      check(rd_data == 16'hB000 + 16'(i), "R7 contents kept", rd_data, 16'hB000 + i);
    end
    check(ovf_flag == 1'b1, "R7 sticky", ovf_flag, 1);
  endtask

  task automatic t_underflow();
    logic [15:0] last;
    last = rd_data;
    check(udf_flag == 1'b0, "R8 clean before", udf_flag, 0);
    do_pop();
    check(rd_data == last, "R8 data held", rd_data, last);
    check(udf_flag == 1'b1, "R8 underflow flag", udf_flag, 1);
    check(ua() == 16, "R8 still empty", ua(), 16);
    tick();
    check(udf_flag == 1'b1, "R8 sticky", udf_flag, 1);
  endtask

  task automatic t_simul();
    do_clr();
    for (int i = 0; i < 5; i++) do_push(16'hC000 + 16'(i));
    do_both(16'hC005);
    check(ua() == 11, "R9 mid usable kept", ua(), 11);
    check(rd_data == 16'hC000, "R9 mid pop", rd_data, 16'hC000);
    check(!ovf_flag && !udf_flag, "R9 mid no flags", {ovf_flag, udf_flag}, 0);
    for (int i = 1; i <= 5; i++) begin
      do_pop();
      check(rd_data == 16'hC000 + 16'(i), "R9 mid order", rd_data, 16'hC000 + i);
    end
    // full
    do_clr();
    for (int i = 0; i < 16; i++) do_push(16'hD000 + 16'(i));
    do_both(16'hBEEF);
    check(ua() == 1, "R9 full pop taken push dropped", ua(), 1);
    check(ovf_flag == 1'b1, "R9 full overflow", ovf_flag, 1);
    check(rd_data == 16'hD000, "R9 full pop data", rd_data, 16'hD000);
    // empty
    do_clr();
    do_both(16'h5A5A);
    check(ua() == 15, "R9 empty push taken", ua(), 15);
    check(udf_flag == 1'b1, "R9 empty underflow", udf_flag, 1);
    check(rd_data == 16'hD000, "R9 empty data held", rd_data, 16'hD000);
    do_pop();
    check(rd_data == 16'h5A5A, "R9 empty pushed word", rd_data, 16'h5A5A);
  endtask

  task automatic t_clear();
    do_clr();
    do_regwr(16'hA000);
    for (int i = 0; i < 16; i++) do_push(16'(i));
    do_push(16'h1);  // overflow
    do_pop();
    fifo_clr = 1; wr_en = 1; wr_data = 16'h7777; tick();
    fifo_clr = 0; wr_en = 0;
    check(ua() == 16, "R10 usable reset", ua(), 16);
    check(reg_rdata[15:13] == 3'b101, "R10 watermark kept", reg_rdata[15:13], 3'b101);
    check(!ovf_flag && !udf_flag, "R10 flags cleared", {ovf_flag, udf_flag}, 0);
    do_push(16'h4242);
    do_pop();
    check(rd_data == 16'h4242, "R10 pointers reset", rd_data, 16'h4242);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_thresholds();
    t_reject();
    t_dma();
    t_overflow();
    t_underflow();
    t_simul();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule